// File: doc/BRIEF.md
# Egress Timestamp Queue with Register Readout

This block records the departure time of every outgoing precision-time event message along with the fields that identify it: the domain number, the message type and the sequence ID. An upstream parser supplies these fields, and the local time counter supplies seconds, nanoseconds and sub-nanoseconds, all on a single-cycle capture strobe. Before the record is stored, a programmable transmit pipeline delay is added to the captured time. This moves the timestamp from the capture point to the wire. The delay is given as whole nanoseconds plus a 16-bit binary fraction of a nanosecond.

Records wait in an eight-entry queue. Software works through a 16-bit register window. A write to the advance register moves the oldest record into four data words, which software then reads and matches against frames it sent earlier. A level interrupt stays high while the queue holds records and the interrupt is enabled. It needs no acknowledge and falls only once the queue has been drained. A capture that arrives while the queue is full is lost, and a sticky overflow flag records the loss.

Top module: `egress_ts_fifo`

## Requirements
- R1: Each capture strobe stores one record holding the domain, message type, sequence ID and delay-corrected time. Records are presented in arrival order, one per advance.
- R2: Data word at address 0: bits 7:0 hold the domain, bits 11:8 the message type, bits 14:12 seconds bits 4:2, and bit 15 is set when the word holds a record.
- R3: Address 1 holds the sequence ID and address 2 holds nanoseconds bits 15:0. At address 3, bits 13:0 hold nanoseconds bits 29:16 and bits 15:14 hold seconds bits 1:0.
- R4: A write to address 4 with bit 0 set loads the oldest queued record into the data words and removes it from the queue. A write to address 4 with bit 0 clear changes nothing.
- R5: An advance while the queue is empty clears all four data words, so the valid bit reads 0.
- R6: The data words keep their contents between advances, and reading them changes no state.
- R7: The stored time equals the captured time plus the delay. The delay nanoseconds are at address 7 and the delay fraction is at address 8. A carry out of the fraction adds one nanosecond. A sum of 1,000,000,000 ns or more wraps the nanoseconds and adds one second, with the five stored second bits wrapping modulo 32.
- R8: Status at address 5: bit 0 is 1 while the queue holds records. The interrupt output equals status bit 0 ANDed with enable bit 0 at address 6, and it needs no acknowledge.
- R9: The queue holds 8 records. A capture into a full queue is dropped and sets the sticky overflow flag at status bit 1. Writing 1 to status bit 1 clears that flag.
- R10: If a capture and an advance fall in the same cycle, the advance takes the record that was oldest before that cycle and the capture is always stored. This holds even when the queue is full, so no overflow occurs. With an empty queue, the advance yields an invalid word and the capture is queued.
- R11: After reset, all readable registers are 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_valid | input | 1 | Capture strobe, one record per cycle high |
| cap_domain | input | 8 | Domain number of the message |
| cap_msgtype | input | 4 | Message type |
| cap_seqid | input | 16 | Sequence ID |
| cap_sec | input | 5 | Low five bits of the counter seconds |
| cap_ns | input | 30 | Counter nanoseconds, below 1,000,000,000 |
| cap_subns | input | 16 | Counter fraction of a nanosecond |
| reg_addr | input | 4 | Register window address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt for pending records |

## Verification
A capture and an advance can land on the same clock edge. The bench provokes this by raising the capture strobe and the advance write in one cycle, in two states: with the queue full and with it empty. In the full case, the scoreboard expects the oldest record in the data words and the overflow flag still clear. It then drains the queue and expects all eight remaining records, the new one last. In the empty case, it expects an invalid data word, and the next advance must return the newly captured record.

// File: rtl/ets_pkg.sv
`timescale 1ns/1ps
// Package: shared record type and register addresses for the egress
// timestamp queue. Assumes a 16-bit register window.
package ets_pkg;
    localparam int SEC_W  = 5;
    localparam int NS_W   = 30;
    localparam int SUB_W  = 16;
    localparam int WORD_W = 16;
    localparam logic [NS_W:0] NS_PER_SEC = 31'd1_000_000_000;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [15:0]      seq;
        logic [3:0]       mtype;
        logic [7:0]       dom;
    } ts_rec_t;

    localparam logic [3:0] A_WORD0  = 4'd0;
    localparam logic [3:0] A_WORD1  = 4'd1;
    localparam logic [3:0] A_WORD2  = 4'd2;
    localparam logic [3:0] A_WORD3  = 4'd3;
    localparam logic [3:0] A_ADV    = 4'd4;
    localparam logic [3:0] A_STAT   = 4'd5;
    localparam logic [3:0] A_IEN    = 4'd6;
    localparam logic [3:0] A_DLYNS  = 4'd7;
    localparam logic [3:0] A_DLYSUB = 4'd8;
endpackage

// File: rtl/ets_delay_add.sv
`timescale 1ns/1ps
// ets_delay_add: adds the transmit pipeline delay to a captured time.
// The fraction carries into nanoseconds; nanoseconds wrap once at one
// second into the truncated seconds field. Assumes in_ns < 1e9 and a
// delay below one second, so at most one wrap occurs. Purely combinational.
module ets_delay_add
    import ets_pkg::*;
(
    input  logic [SEC_W-1:0]  in_sec,
    input  logic [NS_W-1:0]   in_ns,
    input  logic [SUB_W-1:0]  in_sub,
    input  logic [15:0]       dly_ns,
    input  logic [SUB_W-1:0]  dly_sub,
    output logic [SEC_W-1:0]  out_sec,
    output logic [NS_W-1:0]   out_ns
);
    logic [SUB_W:0] sub_sum;
    logic [NS_W:0]  ns_sum;

    // Sum fraction and nanoseconds, then fold one second if needed.
    always_comb begin
        sub_sum = {1'b0, in_sub} + {1'b0, dly_sub};
        ns_sum  = {1'b0, in_ns} + {{(NS_W-15){1'b0}}, dly_ns}
                  + {{NS_W{1'b0}}, sub_sum[SUB_W]};
        if (ns_sum >= NS_PER_SEC) begin
            out_ns  = NS_W'(ns_sum - NS_PER_SEC);
            out_sec = in_sec + 1'b1;
        end else begin
            out_ns  = ns_sum[NS_W-1:0];
            out_sec = in_sec;
        end
    end

    // Result stays within one second when the input does.
    always_comb begin
        if ({1'b0, in_ns} < NS_PER_SEC)
            p_ns_in_range_r7: assert ({1'b0, out_ns} < NS_PER_SEC);
    end
endmodule

// File: rtl/ets_fifo.sv
`timescale 1ns/1ps
// ets_fifo: record queue. A push into a full queue is dropped unless a
// pop happens in the same cycle. The head is visible combinationally.
// Assumes DEPTH is a power of two.
module ets_fifo
    import ets_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  ts_rec_t din,
    input  logic    pop,
    output ts_rec_t dout,
    output logic    empty,
    output logic    drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    ts_rec_t            mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;
    logic               full, do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign dout    = mem[rd_ptr];

    // Store accepted records.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));
    p_both_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty) |=> (count == $past(count)));
endmodule

// File: rtl/ets_window.sv
`timescale 1ns/1ps
// ets_window: 16-bit register window. Holds the four data words, the
// status and enable bits and the delay settings, and makes the pop
// request. Reads are side-effect free.
module ets_window
    import ets_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  ts_rec_t           head,
    input  logic              q_empty,
    input  logic              q_drop,
    output logic              pop,
    output logic [WORD_W-1:0] rdata,
    output logic              irq,
    output logic [15:0]       dly_ns,
    output logic [SUB_W-1:0]  dly_sub
);
    ts_rec_t hold;
    logic    hold_vld;
    logic    ovf, ien, ovf_clr;

    assign pop     = wr && (addr == A_ADV) && wdata[0];
    assign ovf_clr = wr && (addr == A_STAT) && wdata[1];
    assign irq     = !q_empty && ien;

    // Load the head record on advance; empty queue yields a cleared word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            hold_vld <= 1'b0;
        end else if (pop) begin
            hold     <= q_empty ? '0 : head;
            hold_vld <= !q_empty;
        end
    end

    // Sticky overflow flag; a new drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      ovf <= 1'b0;
        else if (q_drop) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    // Software settings: interrupt enable and pipeline delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= 1'b0;
            dly_ns  <= '0;
            dly_sub <= '0;
        end else if (wr) begin
            if (addr == A_IEN)    ien     <= wdata[0];
            if (addr == A_DLYNS)  dly_ns  <= wdata;
            if (addr == A_DLYSUB) dly_sub <= wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_WORD0:  rdata = {hold_vld, hold.sec[4:2], hold.mtype, hold.dom};
            A_WORD1:  rdata = hold.seq;
            A_WORD2:  rdata = hold.ns[15:0];
            A_WORD3:  rdata = {hold.sec[1:0], hold.ns[29:16]};
            A_STAT:   rdata = {14'd0, ovf, !q_empty};
            A_IEN:    rdata = {15'd0, ien};
            A_DLYNS:  rdata = dly_ns;
            A_DLYSUB: rdata = dly_sub;
            default:  rdata = '0;
        endcase
    end

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !pop && !(wr && addr == A_IEN)) |=> irq);
    p_empty_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && q_empty) |=> !hold_vld);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> ($stable(hold) && $stable(hold_vld)));
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/egress_ts_fifo.sv
`timescale 1ns/1ps
// egress_ts_fifo: top. Corrects each captured egress time by the pipeline
// delay, queues the record and exposes it through the register window.
// Assumes frame parsing upstream and at most one capture per cycle.
module egress_ts_fifo
    import ets_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_valid,
    input  logic [7:0]  cap_domain,
    input  logic [3:0]  cap_msgtype,
    input  logic [15:0] cap_seqid,
    input  logic [4:0]  cap_sec,
    input  logic [29:0] cap_ns,
    input  logic [15:0] cap_subns,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    ts_rec_t          rec_in, head;
    logic [SEC_W-1:0] adj_sec;
    logic [NS_W-1:0]  adj_ns;
    logic [15:0]      dly_ns;
    logic [SUB_W-1:0] dly_sub;
    logic             pop, q_empty, q_drop;

    ets_delay_add u_add (
        .in_sec(cap_sec), .in_ns(cap_ns), .in_sub(cap_subns),
        .dly_ns(dly_ns), .dly_sub(dly_sub),
        .out_sec(adj_sec), .out_ns(adj_ns)
    );

    // Assemble the record to be queued.
    always_comb begin
        rec_in.sec   = adj_sec;
        rec_in.ns    = adj_ns;
        rec_in.seq   = cap_seqid;
        rec_in.mtype = cap_msgtype;
        rec_in.dom   = cap_domain;
    end

    ets_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(cap_valid), .din(rec_in),
        .pop(pop), .dout(head), .empty(q_empty), .drop(q_drop)
    );

    ets_window u_win (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .head(head), .q_empty(q_empty), .q_drop(q_drop),
        .pop(pop), .rdata(reg_rdata), .irq(irq),
        .dly_ns(dly_ns), .dly_sub(dly_sub)
    );
endmodule

// File: tb/egress_ts_fifo_test.sv
`timescale 1ns/1ps
module egress_ts_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [7:0]  cap_domain = '0;
    logic [3:0]  cap_msgtype = '0;
    logic [15:0] cap_seqid = '0;
    logic [4:0]  cap_sec = '0;
    logic [29:0] cap_ns = '0;
    logic [15:0] cap_subns = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    logic [63:0] sbq[$];       // expected {w3,w2,w1,w0}
    int unsigned m_dly_ns = 0;
    int unsigned m_dly_sub = 0;

    always #2.5 clk = ~clk;

    egress_ts_fifo uut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Model of the stored words (R2, R3, R7).
    function automatic logic [63:0] model(input logic [7:0] d, input logic [3:0] t,
        input logic [15:0] s, input logic [4:0] sec, input logic [29:0] ns, input logic [15:0] sub);
        longint unsigned tot;
        logic [4:0] osec;
        logic [29:0] ons;
        tot  = longint'(ns) + m_dly_ns + ((longint'(sub) + m_dly_sub) >> 16);
        osec = sec;
        if (tot >= 64'd1_000_000_000) begin
            tot  = tot - 64'd1_000_000_000;
            osec = sec + 5'd1;
        end
        ons = tot[29:0];
        return {{osec[1:0], ons[29:16]}, ons[15:0], s, {1'b1, osec[4:2], t, d}};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Driver: one capture, scoreboard updated per R1/R9.
    task automatic cap(input logic [7:0] d, input logic [3:0] t, input logic [15:0] s,
                       input logic [4:0] sec, input logic [29:0] ns, input logic [15:0] sub);
        @(negedge clk);
        cap_domain = d; cap_msgtype = t; cap_seqid = s;
        cap_sec = sec; cap_ns = ns; cap_subns = sub; cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
        if (sbq.size() < 8) sbq.push_back(model(d, t, s, sec, ns, sub));
    endtask

    task automatic cmp_words(input string req, input logic [63:0] exp);
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(4'(i), v);
            check(req, v, exp[16*i +: 16]);
        end
    endtask

    // Monitor: advance and compare against the queue head.
    task automatic pop_check(input string req);
        logic [63:0] exp;
        wr(4'd4, 16'h0001);
        exp = (sbq.size() == 0) ? 64'd0 : sbq.pop_front();
        cmp_words(req, exp);
    endtask

    // Capture and advance in the same cycle (R10).
    task automatic both(input logic [7:0] d, input logic [15:0] s);
        logic [63:0] exp;
        @(negedge clk);
        cap_domain = d; cap_msgtype = 4'h3; cap_seqid = s;
        cap_sec = 5'd2; cap_ns = 30'd500; cap_subns = 16'd0; cap_valid = 1'b1;
        reg_addr = 4'd4; reg_wdata = 16'h0001; reg_wr = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0; reg_wr = 1'b0;
        exp = (sbq.size() == 0) ? 64'd0 : sbq.pop_front();
        sbq.push_back(model(d, 4'h3, s, 5'd2, 30'd500, 16'd0));
        cmp_words("R10", exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] w0a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v);
            check("R11", v, 16'h0000);
        end
        check("R11 irq", {15'd0, irq}, 16'h0000);

        // R1/R2/R3/R7 basic captures with delay
        wr(4'd7, 16'd40); m_dly_ns = 40;
        wr(4'd8, 16'h8000); m_dly_sub = 16'h8000;
        wr(4'd6, 16'h0001);
        cap(8'h12, 4'h0, 16'h0101, 5'd7, 30'd123_456_789, 16'h8000);
        cap(8'hA5, 4'h2, 16'hBEEF, 5'd21, 30'd65_535, 16'h0001);
        cap(8'h00, 4'hF, 16'hFFFF, 5'd0, 30'd0, 16'h0000);
        check("R8 irq pending", {15'd0, irq}, 16'h0001);
        rd(4'd5, v); check("R8 status", v, 16'h0001);
        pop_check("R1 R2 R3 R7");
        // R6: repeated reads, then a write with bit0 clear (R4)
        rd(4'd0, w0a); rd(4'd0, v); check("R6", v, w0a);
        wr(4'd4, 16'h0002);
        rd(4'd0, v); check("R4 no advance", v, w0a);
        pop_check("R1 R3");
        check("R8 still pending", {15'd0, irq}, 16'h0001);
        pop_check("R1 R2");
        check("R8 drained", {15'd0, irq}, 16'h0000);
        // R5 advance on empty
        pop_check("R5");

        // R7 wraps: fraction carry, ns rollover, seconds mod 32
        wr(4'd7, 16'd20); m_dly_ns = 20;
        wr(4'd8, 16'h0001); m_dly_sub = 1;
        cap(8'h33, 4'h1, 16'h0042, 5'd31, 30'd999_999_979, 16'hFFFF);
        pop_check("R7 wrap");
        cap(8'h34, 4'h1, 16'h0043, 5'd4, 30'd999_999_990, 16'h0000);
        pop_check("R7 rollover");

        // R8 enable gate
        wr(4'd6, 16'h0000);
        cap(8'h01, 4'h0, 16'h0001, 5'd1, 30'd1, 16'd0);
        check("R8 gated", {15'd0, irq}, 16'h0000);
        rd(4'd5, v); check("R8 status gated", v, 16'h0001);
        pop_check("R1");

        // R9 overflow
        for (int i = 0; i < 9; i++)
            cap(8'(i), 4'h2, 16'(16'h100 + i), 5'(i), 30'(i * 1000), 16'd0);
        rd(4'd5, v); check("R9 overflow set", v, 16'h0003);
        for (int i = 0; i < 8; i++) pop_check("R9");
        rd(4'd5, v); check("R9 sticky", v, 16'h0002);
        wr(4'd5, 16'h0002);
        rd(4'd5, v); check("R9 cleared", v, 16'h0000);

        // R10 full queue with simultaneous capture and advance
        for (int i = 0; i < 8; i++)
            cap(8'(8'h40 + i), 4'h1, 16'(16'h200 + i), 5'd3, 30'(i), 16'd0);
        both(8'h77, 16'h7777);
        rd(4'd5, v); check("R10 no overflow", v, 16'h0001);
        for (int i = 0; i < 8; i++) pop_check("R10 drain");
        rd(4'd5, v); check("R10 empty", v, 16'h0000);
        // R10 empty queue with simultaneous capture and advance
        both(8'h78, 16'h7878);
        pop_check("R10 new");

        summary();
        $finish;
    end
endmodule